// File: doc/BRIEF.md
# Walking-Pattern Register Test Engine

This block is a self-contained test sequencer that masters a simple register bus with separate setup and access phases. After a start request it reads and saves the target register's current content. It then sweeps a single set bit upward from bit 0, and after that a single cleared bit upward from bit 0. Every pattern is written and then read back from the same address. Each readback is compared against the written pattern, but only on the bits the caller declares writable and does not exclude. The exclusion mask covers bits the design under test may change by itself, such as a completion flag raised by an enable bit.

The first mismatch is captured together with the phase it occurred in. The caller chooses whether the sweep keeps going or cuts short after that first mismatch. In both cases the saved original value is written back at the end. The engine then pulses a completion strobe for one cycle and leaves a pass flag that holds until the next run.

Top module: `regwalk_engine`

## Requirements
- R1: While reset is high, and after it is released, psel_o, penable_o, busy_o, done_o and pass_o are all low.
- R2: The first bus access of a run is a read of the target. The first DW writes that follow carry exactly one set bit, starting at bit 0 and moving up by one position per write.
- R3: The next DW writes carry all ones except one cleared bit, starting with bit 0 cleared and moving up by one position per write.
- R4: Every test write is followed by one read. Every access of a run uses the target address latched at start. A full run makes 2*DW+1 reads and 2*DW+1 writes.
- R5: A readback is a mismatch only if it differs from the pattern in a bit that is set in wr_mask_i and clear in ign_mask_i. Read-only and stuck bits outside that set do not fail the test.
- R6: A bit set in ign_mask_i never causes a mismatch, even when the target changes it by itself after a write.
- R7: On the first mismatch of a run, fail_pat_o, fail_rdata_o and fail_phase_o (0 = single set bit, 1 = single cleared bit) capture the written pattern, the read data and the phase. Later mismatches leave them unchanged.
- R8: With stop_on_err_i low the sweep always completes. With it high, the first mismatching read is followed directly by the restore write.
- R9: The last write of every run carries the value returned by the run's first read.
- R10: done_o is high for exactly one cycle, (4+W)*2*K clock edges after the edge that samples start_i. Here K is the number of writes in the run and W is the number of wait cycles per access. At that strobe pass_o becomes 1 if no mismatch occurred, and it holds until the next accepted start, which clears it.
- R11: Each access asserts psel_o alone for one cycle, then psel_o with penable_o. It keeps address, direction and data steady until pready_i is high. penable_o is never high without psel_o.
- R12: start_i is ignored while busy_o is high. Pulsing it mid-run changes neither the write sequence nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run when idle |
| tgt_addr_i | input | AW | Address of the register under test |
| wr_mask_i | input | DW | Bits that are writable and readable |
| ign_mask_i | input | DW | Bits excluded from compare |
| stop_on_err_i | input | 1 | Cut the sweep short at the first mismatch |
| psel_o | output | 1 | Bus select |
| penable_o | output | 1 | Bus access phase |
| pwrite_o | output | 1 | Bus direction, 1 = write |
| paddr_o | output | AW | Bus address |
| pwdata_o | output | DW | Bus write data |
| prdata_i | input | DW | Bus read data |
| pready_i | input | 1 | Bus transfer completion |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| pass_o | output | 1 | Sticky result of the last run |
| fail_pat_o | output | DW | Pattern of the first mismatch |
| fail_rdata_o | output | DW | Read data of the first mismatch |
| fail_phase_o | output | 1 | Phase of the first mismatch |

## Verification
Each bus access takes four cycles plus the target's wait cycles: request, setup, access, acknowledge. The bench therefore predicts the completion strobe after exactly 2*K*(4+W) edges, counted from the edge that samples start. The captured failure fields and the pass flag are read at the falling edge where the strobe is seen. The bench's target model logs every write and read on the edge where pready_i completes the access. Write order, restore value and address are compared against that log only after the strobe.

// File: rtl/regwalk_pkg.sv
package regwalk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE_REQ,
    ST_SAVE_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_RST_REQ,
    ST_RST_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_SETUP,
    BUS_ACCESS
  } bus_state_t;

  typedef enum logic {
    PH_ONE  = 1'b0,
    PH_ZERO = 1'b1
  } walk_phase_t;

endpackage

// File: rtl/regwalk_apb_master.sv
module regwalk_apb_master
  import regwalk_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          psel_o,
  output logic          penable_o,
  output logic          pwrite_o,
  output logic [AW-1:0] paddr_o,
  output logic [DW-1:0] pwdata_o,
  input  logic [DW-1:0] prdata_i,
  input  logic          pready_i
);

  bus_state_t bus_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_st    <= BUS_IDLE;
      psel_o    <= 1'b0;
      penable_o <= 1'b0;
      pwrite_o  <= 1'b0;
      paddr_o   <= '0;
      pwdata_o  <= '0;
      ack_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      ack_o <= 1'b0;
      case (bus_st)
        BUS_IDLE: begin
          if (req_i) begin
            psel_o   <= 1'b1;
            pwrite_o <= req_write_i;
            paddr_o  <= req_addr_i;
            pwdata_o <= req_wdata_i;
            bus_st   <= BUS_SETUP;
          end
        end
        BUS_SETUP: begin
          penable_o <= 1'b1;
          bus_st    <= BUS_ACCESS;
        end
        BUS_ACCESS: begin
          if (pready_i) begin
            psel_o    <= 1'b0;
            penable_o <= 1'b0;
            rdata_o   <= prdata_i;
            ack_o     <= 1'b1;
            bus_st    <= BUS_IDLE;
          end
        end
        default: bus_st <= BUS_IDLE;
      endcase
    end
  end

  AST_EN_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    penable_o |-> psel_o); // R11

  AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (psel_o && !penable_o) |=> (psel_o && penable_o)); // R11

  AST_HOLD_TILL_READY: assert property (@(posedge clk) disable iff (rst)
    (psel_o && penable_o && !pready_i) |=>
      (psel_o && penable_o && $stable(paddr_o) && $stable(pwrite_o) && $stable(pwdata_o))); // R11

endmodule

// File: rtl/regwalk_patgen.sv
module regwalk_patgen
  import regwalk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [DW-1:0] pattern_o,
  output walk_phase_t   phase_o,
  output logic          last_o
);

  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(DW - 1);

  logic [IW-1:0] idx_q;
  walk_phase_t   phase_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      idx_q   <= '0;
      phase_q <= PH_ONE;
    end else if (step_i) begin
      if (idx_q == TOP_IDX) begin
        idx_q   <= '0;
        phase_q <= PH_ZERO;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign pattern_o[b] = (idx_q == IW'(b)) ^ phase_q;
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == PH_ZERO) && (idx_q == TOP_IDX);

  AST_W1_SINGLE_SET: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_ONE) |-> ($countones(pattern_o) == 1)); // R2

  AST_W0_SINGLE_CLR: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_ZERO) |-> ($countones(~pattern_o) == 1)); // R3

endmodule

// File: rtl/regwalk_judge.sv
module regwalk_judge
  import regwalk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          chk_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] pattern_i,
  input  walk_phase_t   phase_i,
  input  logic [DW-1:0] wr_mask_i,
  input  logic [DW-1:0] ign_mask_i,
  output logic          mismatch_o,
  output logic          fail_seen_o,
  output logic [DW-1:0] first_pat_o,
  output logic [DW-1:0] first_rdata_o,
  output logic          first_phase_o
);

  logic [DW-1:0] cmp_bits;
  logic [DW-1:0] diff_bits;

  assign cmp_bits   = wr_mask_i & ~ign_mask_i;
  assign diff_bits  = (rdata_i ^ pattern_i) & cmp_bits;
  assign mismatch_o = |diff_bits;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      fail_seen_o   <= 1'b0;
      first_pat_o   <= '0;
      first_rdata_o <= '0;
      first_phase_o <= 1'b0;
    end else if (chk_i && mismatch_o && !fail_seen_o) begin
      fail_seen_o   <= 1'b1;
      first_pat_o   <= pattern_i;
      first_rdata_o <= rdata_i;
      first_phase_o <= phase_i;
    end
  end

  AST_FIRST_FAIL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (fail_seen_o && !clear_i) |=>
      ($stable(first_pat_o) && $stable(first_rdata_o) && $stable(first_phase_o))); // R7

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail_seen_o && !clear_i) |=> fail_seen_o); // R7

endmodule

// File: rtl/regwalk_engine.sv
module regwalk_engine
  import regwalk_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [DW-1:0] wr_mask_i,
  input  logic [DW-1:0] ign_mask_i,
  input  logic          stop_on_err_i,
  output logic          psel_o,
  output logic          penable_o,
  output logic          pwrite_o,
  output logic [AW-1:0] paddr_o,
  output logic [DW-1:0] pwdata_o,
  input  logic [DW-1:0] prdata_i,
  input  logic          pready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [DW-1:0] fail_pat_o,
  output logic [DW-1:0] fail_rdata_o,
  output logic          fail_phase_o
);

  seq_state_t    state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wmask_q;
  logic [DW-1:0] imask_q;
  logic          stop_q;
  logic [DW-1:0] orig_q;
  logic          done_q;
  logic          pass_q;

  logic          req;
  logic          req_write;
  logic [DW-1:0] req_wdata;
  logic          ack;
  logic [DW-1:0] bus_rdata;

  logic [DW-1:0] pattern;
  walk_phase_t   phase;
  logic          last_pat;
  logic          mismatch;
  logic          fail_seen;

  logic          accept;
  logic          rd_done;
  logic          finish_walk;
  logic          step;

  assign accept      = (state_q == ST_IDLE) && start_i;
  assign rd_done     = (state_q == ST_RD_WAIT) && ack;
  assign finish_walk = last_pat || (stop_q && mismatch);
  assign step        = rd_done && !finish_walk;

  assign req       = (state_q == ST_SAVE_REQ) || (state_q == ST_WR_REQ) ||
                     (state_q == ST_RD_REQ)   || (state_q == ST_RST_REQ);
  assign req_write = (state_q == ST_WR_REQ) || (state_q == ST_RST_REQ);
  assign req_wdata = (state_q == ST_RST_REQ) ? orig_q : pattern;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wmask_q <= '0;
      imask_q <= '0;
      stop_q  <= 1'b0;
      orig_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q  <= tgt_addr_i;
            wmask_q <= wr_mask_i;
            imask_q <= ign_mask_i;
            stop_q  <= stop_on_err_i;
            pass_q  <= 1'b0;
            state_q <= ST_SAVE_REQ;
          end
        end
        ST_SAVE_REQ: state_q <= ST_SAVE_WAIT;
        ST_SAVE_WAIT: begin
          if (ack) begin
            orig_q  <= bus_rdata;
            state_q <= ST_WR_REQ;
          end
        end
        ST_WR_REQ: state_q <= ST_WR_WAIT;
        ST_WR_WAIT: begin
          if (ack) state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: state_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (ack) state_q <= finish_walk ? ST_RST_REQ : ST_WR_REQ;
        end
        ST_RST_REQ: state_q <= ST_RST_WAIT;
        ST_RST_WAIT: begin
          if (ack) begin
            done_q  <= 1'b1;
            pass_q  <= !fail_seen;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  regwalk_apb_master #(.AW(AW), .DW(DW)) u_bus (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req),
    .req_write_i (req_write),
    .req_addr_i  (addr_q),
    .req_wdata_i (req_wdata),
    .ack_o       (ack),
    .rdata_o     (bus_rdata),
    .psel_o      (psel_o),
    .penable_o   (penable_o),
    .pwrite_o    (pwrite_o),
    .paddr_o     (paddr_o),
    .pwdata_o    (pwdata_o),
    .prdata_i    (prdata_i),
    .pready_i    (pready_i)
  );

  regwalk_patgen #(.DW(DW)) u_pat (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (accept),
    .step_i    (step),
    .pattern_o (pattern),
    .phase_o   (phase),
    .last_o    (last_pat)
  );

  regwalk_judge #(.DW(DW)) u_judge (
    .clk           (clk),
    .rst           (rst),
    .clear_i       (accept),
    .chk_i         (rd_done),
    .rdata_i       (bus_rdata),
    .pattern_i     (pattern),
    .phase_i       (phase),
    .wr_mask_i     (wmask_q),
    .ign_mask_i    (imask_q),
    .mismatch_o    (mismatch),
    .fail_seen_o   (fail_seen),
    .first_pat_o   (fail_pat_o),
    .first_rdata_o (fail_rdata_o),
    .first_phase_o (fail_phase_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign pass_o = pass_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R10

  AST_PASS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i && !done_o) |=> $stable(pass_o)); // R10

  AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (rst)
    psel_o |-> (paddr_o == addr_q)); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(addr_q)); // R12

endmodule

// File: tb/regwalk_engine_bench.sv
`timescale 1ns/1ps
module regwalk_engine_bench;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] tgt = '0;
  logic [DW-1:0] wmask = '0;
  logic [DW-1:0] imask = '0;
  logic          stop = 1'b0;
  logic          psel, penable, pwrite, pready;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata, prdata;
  logic          busy, done, pass;
  logic [DW-1:0] fpat, frd;
  logic          fph;

  int checks = 0;
  int errors = 0;

  // target model
  logic [DW-1:0] m_store = '0;
  logic [DW-1:0] m_rw = '1;
  logic [DW-1:0] m_ro = '0;
  logic [DW-1:0] m_st0 = '0;
  logic [DW-1:0] m_st1 = '0;
  logic          m_flag = 1'b0;
  int            m_wait = 0;
  int            acc_cnt = 0;

  logic [DW-1:0] wr_log [0:63];
  int wr_n = 0;
  int rd_n = 0;
  int addr_bad = 0;
  int first_is_write = -1;
  int dn_cnt = 0;

  always #4 clk = ~clk;

  regwalk_engine #(.AW(AW), .DW(DW)) u_regwalk_engine (
    .clk(clk), .rst(rst), .start_i(start), .tgt_addr_i(tgt),
    .wr_mask_i(wmask), .ign_mask_i(imask), .stop_on_err_i(stop),
    .psel_o(psel), .penable_o(penable), .pwrite_o(pwrite), .paddr_o(paddr),
    .pwdata_o(pwdata), .prdata_i(prdata), .pready_i(pready),
    .busy_o(busy), .done_o(done), .pass_o(pass),
    .fail_pat_o(fpat), .fail_rdata_o(frd), .fail_phase_o(fph)
  );

  function automatic logic [DW-1:0] mread(input logic [DW-1:0] s);
    logic [DW-1:0] v;
    v = (s & m_rw) | (m_ro & ~m_rw);
    v = (v & ~m_st0) | m_st1;
    if (m_flag && v[2] && v[3]) v[9] = 1'b1;
    return v;
  endfunction

  assign prdata = mread(m_store);
  assign pready = (acc_cnt >= m_wait);

  always @(posedge clk) begin
    if (psel && penable && !pready) acc_cnt <= acc_cnt + 1;
    else acc_cnt <= 0;
    if (psel && penable && pready) begin
      if (first_is_write < 0) first_is_write <= int'(pwrite);
      if (paddr != tgt) addr_bad <= addr_bad + 1;
      if (pwrite) begin
        wr_log[wr_n] <= pwdata;
        wr_n <= wr_n + 1;
        m_store <= pwdata;
      end else begin
        rd_n <= rd_n + 1;
      end
    end
  end

  always @(negedge clk) if (done) dn_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected results from the requirements
  logic          e_fail;
  logic [DW-1:0] e_pat, e_rd;
  logic          e_ph;
  int            e_writes;
  logic [DW-1:0] e_restore;

  task automatic predict(input logic [DW-1:0] init);
    logic [DW-1:0] p, r;
    bit halt;
    e_fail = 0; e_pat = '0; e_rd = '0; e_ph = 0; e_writes = 0; halt = 0;
    e_restore = mread(init);
    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < DW; i++) begin
        if (!halt) begin
          p = (DW'(1) << i);
          if (ph == 1) p = ~p;
          e_writes++;
          r = mread(p);
          if ((((r ^ p) & wmask & ~imask) != '0) && !e_fail) begin
            e_fail = 1; e_pat = p; e_rd = r; e_ph = ph[0];
            if (stop) halt = 1;
          end
        end
      end
    end
    e_writes++;
  endtask

  task automatic run(input logic [DW-1:0] init, input int poke_at, input string tag);
    int lat;
    @(negedge clk);
    m_store = init;
    wr_n = 0; rd_n = 0; addr_bad = 0; first_is_write = -1; dn_cnt = 0;
    predict(init);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(pass == 1'b0 && busy == 1'b1, {tag, " R10 pass cleared by start"}, {pass, busy}, 2'b01);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == poke_at) start = 1'b1;
      else start = 1'b0;
    end while (!done && lat < 20000);
    start = 1'b0;
    chk(lat == 2 * e_writes * (4 + m_wait), {tag, " R10 R12 done latency"}, lat, 2 * e_writes * (4 + m_wait));
    chk(pass == !e_fail, {tag, " R10 pass flag"}, pass, !e_fail);
    if (e_fail) begin
      chk(fpat == e_pat, {tag, " R7 fail pattern"}, fpat, e_pat);
      chk(frd == e_rd, {tag, " R7 fail read data"}, frd, e_rd);
      chk(fph == e_ph, {tag, " R7 fail phase"}, fph, e_ph);
    end
    repeat (4) @(negedge clk);
    chk(dn_cnt == 1, {tag, " R10 done width"}, dn_cnt, 1);
    chk(pass == !e_fail, {tag, " R10 pass sticky"}, pass, !e_fail);
    chk(wr_n == e_writes, {tag, " R8 write count"}, wr_n, e_writes);
    chk(rd_n == e_writes, {tag, " R4 read count"}, rd_n, e_writes);
    chk(addr_bad == 0, {tag, " R4 address"}, addr_bad, 0);
    chk(first_is_write == 0, {tag, " R2 first access is read"}, first_is_write, 0);
    chk(wr_log[wr_n - 1] == e_restore, {tag, " R9 restore value"}, wr_log[wr_n - 1], e_restore);
  endtask

  task automatic check_patterns(input string tag);
    int bad1 = 0, bad0 = 0;
    for (int i = 0; i < DW; i++) begin
      if (wr_log[i] != (DW'(1) << i)) bad1++;
      if (wr_log[DW + i] != ~(DW'(1) << i)) bad0++;
    end
    chk(bad1 == 0, {tag, " R2 single set bit sweep"}, bad1, 0);
    chk(bad0 == 0, {tag, " R3 single cleared bit sweep"}, bad0, 0);
  endtask

  task automatic model_clean();
    m_rw = '1; m_ro = '0; m_st0 = '0; m_st1 = '0; m_flag = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({psel, penable, busy, done, pass} == 5'b0, "R1 in reset", {psel, penable, busy, done, pass}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk({psel, penable, busy, done, pass} == 5'b0, "R1 after reset", {psel, penable, busy, done, pass}, 0);
  endtask

  task automatic t_clean();
    model_clean(); m_wait = 0; tgt = 8'h34; wmask = '1; imask = '0; stop = 0;
    run(16'h5A3C, -1, "clean");
    chk(pass == 1'b1, "R5 clean register passes", pass, 1);
    check_patterns("clean");
  endtask

  task automatic t_stuck0();
    model_clean(); m_st0 = 16'h0020; m_wait = 1; tgt = 8'h10; wmask = '1; imask = '0; stop = 0;
    run(16'h0F0F, -1, "stuck0");
    chk(fpat == 16'h0020 && frd == 16'h0000 && fph == 1'b0, "R7 stuck-at-0 first in set-bit phase", fpat, 16'h0020);
    chk(wr_n == 2 * DW + 1, "R8 no stop completes sweep", wr_n, 2 * DW + 1);
    check_patterns("stuck0");
  endtask

  task automatic t_stuck1_stop();
    model_clean(); m_st1 = 16'h0008; m_wait = 2; tgt = 8'h22; wmask = '1; imask = '0; stop = 1;
    run(16'h1234, -1, "stuck1");
    chk(wr_n == 2, "R8 stop after first mismatch", wr_n, 2);
    chk(frd == 16'h0009, "R5 stuck-at-1 seen", frd, 16'h0009);
  endtask

  task automatic t_flag_fail();
    model_clean(); m_flag = 1; m_wait = 0; tgt = 8'h44; wmask = '1; imask = '0; stop = 1;
    run(16'h0000, -1, "flag");
    chk(fph == 1'b1 && fpat == 16'hFDFF && frd == 16'hFFFF, "R7 flag mismatch in cleared-bit phase", frd, 16'hFFFF);
    chk(wr_n == DW + 10 + 1, "R8 stop in second phase", wr_n, DW + 11);
  endtask

  task automatic t_flag_ignored();
    model_clean(); m_flag = 1; m_wait = 1; tgt = 8'h44; wmask = '1; imask = 16'h0200; stop = 1;
    run(16'h0000, -1, "ignore");
    chk(pass == 1'b1, "R6 ignored self-updating bit", pass, 1);
  endtask

  task automatic t_readonly();
    model_clean(); m_rw = 16'h0FFF; m_ro = 16'hA000; m_wait = 0; tgt = 8'h08; wmask = 16'h0FFF; imask = '0; stop = 0;
    run(16'h0123, -1, "ro_masked");
    chk(pass == 1'b1, "R5 read-only bits outside write mask", pass, 1);
    wmask = '1;
    run(16'h0123, -1, "ro_unmasked");
    chk(fpat == 16'h0001 && frd == 16'hA001, "R5 read-only bits inside write mask fail", frd, 16'hA001);
  endtask

  task automatic t_start_busy();
    model_clean(); m_wait = 0; tgt = 8'h7E; wmask = '1; imask = '0; stop = 0;
    run(16'hC3C3, 20, "restart");
    chk(wr_n == 2 * DW + 1, "R12 start while busy ignored", wr_n, 2 * DW + 1);
    check_patterns("restart");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_clean();
    t_stuck0();
    t_stuck1_stop();
    t_flag_fail();
    t_flag_ignored();
    t_readonly();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule